// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Engine

This block moves a disk channel's data between a 16-bit device stream and system memory without the processor copying it. Software sets up a table of 8-byte descriptors in memory. Each descriptor names a buffer and its length, and the final one carries an end marker. Software then loads the table's address into the engine and sets the start bit, together with a direction bit. The engine reads descriptors one at a time and moves one 16-bit word at a time through a simple request/acknowledge memory port. It stops when the device signals that it has nothing more to move, or when the last descriptor has been used up.

How the run ends is recorded in the status byte, where software reads the active, error and interrupt flags. If the device finishes exactly as the last buffer fills, interrupt is set and active is cleared. If the table runs out while the device still has data, active is cleared and no interrupt is raised. If the device finishes while buffer space is left over, interrupt is set and active stays set until software writes a stop. A memory access that returns an error ends the run with the error and interrupt flags set.

Top module: `dma_desc_engine`

## Requirements
- R1: The register port is byte-wide at three-bit offsets: 0 = command (bit 0 start, bit 3 direction, 1 = device to memory), 2 = status (bit 0 active, bit 1 error, bit 2 interrupt), 4..7 = table address bytes, least significant byte at offset 4. Offsets 1 and 3 read 0. Reads are combinational.
- R2: The table address always reads with its two low bits at 0. Any write to offsets 4..7 while active is set leaves the address unchanged.
- R3: A write to offset 0 with bit 0 set, while the stored start bit is 0, sets active. The engine then reads the 32-bit buffer address at the table address and the 32-bit size word at the table address plus 4, then moves on 8 bytes for each following descriptor. A start write while active is already set has no effect and causes no memory access.
- R4: A descriptor's byte count is taken from size bits 15:0 with bit 0 forced to 0, and a count of 0 means 65536. Bit 31 marks the last descriptor. Bit 0 of the buffer address is ignored.
- R5: With direction 1, each device word is written to memory at consecutive even addresses across descriptors. With direction 0, memory words are read in the same address order and handed to the device in that order.
- R6: If the device signals done when the last descriptor's count is used up, status becomes interrupt=1, active=0.
- R7: If the last descriptor's count is used up before the device signals done, status becomes active=0, interrupt=0, and no further device words are taken.
- R8: If the device signals done while buffer space remains, status becomes interrupt=1, active=1, and no further memory access is made.
- R9: A write to offset 0 with bit 0 clear clears active in the next cycle and stops memory requests. It leaves the interrupt flag as it was.
- R10: Writing 1 to status bit 2 clears interrupt, and writing 1 to status bit 1 clears error. Writing 0 to either bit leaves it unchanged.
- R11: A memory acknowledge that carries an error sets error and interrupt, clears active, and performs no further access.
- R12: The interrupt output is high whenever the interrupt status flag or the device interrupt request input is high.
- R13: A memory request keeps its address until it is acknowledged. A word offered to the device keeps its value until the device accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 32 | Memory read data (descriptor words whole, data in bits 15:0) |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Acknowledge carries an error |
| dev_in_data | input | 16 | Word from the device |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_ready | output | 1 | Engine takes the offered word |
| dev_out_data | output | 16 | Word to the device |
| dev_out_valid | output | 1 | Engine offers a word |
| dev_out_ready | input | 1 | Device takes the offered word |
| dev_done | input | 1 | Device has no more words to move |
| dev_irq | input | 1 | Device interrupt request |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest case to reach from the ports is exact completion. Here the device's done signal has to appear in the same cycle as the engine checks after the last word of the last descriptor. The bench's device model drives done from its own count of words moved, updated on the same clock edge as the handshake, so done rises in the cycle right after the final transfer. The bench then sweeps the device word count from 1 to 7 against a two-descriptor table holding five words, in both directions. This covers long tables, including one that finishes on a descriptor boundary, the exact case and short tables, with the device-side acceptance stalled on alternate cycles in half the read runs.

// File: rtl/dma_desc_engine.sv
module dma_desc_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [15:0] dev_in_data,
  input  logic        dev_in_valid,
  output logic        dev_in_ready,
  output logic [15:0] dev_out_data,
  output logic        dev_out_valid,
  input  logic        dev_out_ready,
  input  logic        dev_done,
  input  logic        dev_irq,
  output logic        irq
);
  typedef enum logic [2:0] {S_IDLE, S_DADDR, S_DSIZE, S_XFER, S_MEM, S_PUSH} st_t;

  st_t         st;
  logic        cmd_go, cmd_dir, busy, err, intr, last;
  logic [31:2] tbl_ptr;
  logic [31:0] cur_ptr;
  logic [31:1] buf_addr;
  logic [16:0] rem;
  logic [15:0] hold;

  logic cmd_wr, sts_wr, ptr_wr, go_edge, stop, rem_zero, bad;
  assign cmd_wr   = reg_wr && reg_addr == 3'd0;
  assign sts_wr   = reg_wr && reg_addr == 3'd2;
  assign ptr_wr   = reg_wr && reg_addr[2] && !busy;
  assign go_edge  = cmd_wr && reg_wdata[0] && !cmd_go;
  assign stop     = cmd_wr && !reg_wdata[0];
  assign rem_zero = rem == 17'd0;
  assign bad      = mem_req && mem_ack && mem_err;

  assign mem_req       = st == S_DADDR || st == S_DSIZE || st == S_MEM;
  assign mem_we        = st == S_MEM && cmd_dir;
  assign mem_wdata     = hold;
  assign dev_out_data  = hold;
  assign dev_out_valid = st == S_PUSH;
  assign dev_in_ready  = st == S_XFER && cmd_dir && !dev_done && !rem_zero && !stop;
  assign irq           = intr | dev_irq;

  always_comb begin
    case (st)
      S_DADDR: mem_addr = cur_ptr;
      S_DSIZE: mem_addr = cur_ptr + 32'd4;
      default: mem_addr = {buf_addr, 1'b0};
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {4'b0, cmd_dir, 2'b0, cmd_go};
      3'd2:    reg_rdata = {5'b0, intr, err, busy};
      3'd4:    reg_rdata = {tbl_ptr[7:2], 2'b00};
      3'd5:    reg_rdata = tbl_ptr[15:8];
      3'd6:    reg_rdata = tbl_ptr[23:16];
      3'd7:    reg_rdata = tbl_ptr[31:24];
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_go <= 1'b0;
      cmd_dir <= 1'b0;
      busy <= 1'b0;
      err <= 1'b0;
      intr <= 1'b0;
      last <= 1'b0;
      tbl_ptr <= '0;
      cur_ptr <= '0;
      buf_addr <= '0;
      rem <= '0;
      hold <= '0;
    end else begin
      if (cmd_wr && !(busy && reg_wdata[0])) begin
        cmd_go  <= reg_wdata[0];
        cmd_dir <= reg_wdata[3];
      end
      if (ptr_wr) begin
        case (reg_addr[1:0])
          2'd0: tbl_ptr[7:2]   <= reg_wdata[7:2];
          2'd1: tbl_ptr[15:8]  <= reg_wdata;
          2'd2: tbl_ptr[23:16] <= reg_wdata;
          default: tbl_ptr[31:24] <= reg_wdata;
        endcase
      end
      if (sts_wr && reg_wdata[2]) intr <= 1'b0;
      if (sts_wr && reg_wdata[1]) err <= 1'b0;

      if (stop) begin
        busy <= 1'b0;
        st <= S_IDLE;
      end else if (go_edge) begin
        busy <= 1'b1;
        cur_ptr <= {tbl_ptr, 2'b00};
        st <= S_DADDR;
      end else if (bad) begin
        err <= 1'b1;
        intr <= 1'b1;
        busy <= 1'b0;
        st <= S_IDLE;
      end else begin
        case (st)
          S_DADDR: if (mem_ack) begin
            buf_addr <= mem_rdata[31:1];
            st <= S_DSIZE;
          end
          S_DSIZE: if (mem_ack) begin
            rem <= (mem_rdata[15:1] == 15'd0) ? 17'h10000 : {1'b0, mem_rdata[15:1], 1'b0};
            last <= mem_rdata[31];
            cur_ptr <= cur_ptr + 32'd8;
            st <= S_XFER;
          end
          S_XFER: begin
            if (dev_done) begin
              intr <= 1'b1;
              if (rem_zero && last) busy <= 1'b0;
              st <= S_IDLE;
            end else if (rem_zero) begin
              if (last) begin
                busy <= 1'b0;
                st <= S_IDLE;
              end else begin
                st <= S_DADDR;
              end
            end else if (cmd_dir) begin
              if (dev_in_valid) begin
                hold <= dev_in_data;
                st <= S_MEM;
              end
            end else begin
              st <= S_MEM;
            end
          end
          S_MEM: if (mem_ack) begin
            if (cmd_dir) begin
              buf_addr <= buf_addr + 31'd1;
              rem <= rem - 17'd2;
              st <= S_XFER;
            end else begin
              hold <= mem_rdata[15:0];
              st <= S_PUSH;
            end
          end
          S_PUSH: if (dev_out_ready) begin
            buf_addr <= buf_addr + 31'd1;
            rem <= rem - 17'd2;
            st <= S_XFER;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module dma_desc_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_wr,
  input logic [7:0]  reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        dev_in_ready,
  input logic        dev_in_valid,
  input logic        dev_out_valid,
  input logic        dev_out_ready,
  input logic [15:0] dev_out_data,
  input logic        busy,
  input logic        err,
  input logic [31:2] ptr
);
  // R2
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr[2]) |=> $stable(ptr));
  // R9
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !reg_wdata[0]) |=> (!busy && !mem_req));
  // R5
  word_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_in_ready && dev_in_valid) |=> (mem_req && mem_we));
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !reg_wr) |=> (mem_req && $stable(mem_addr)));
  // R13
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready && !reg_wr) |=> (dev_out_valid && $stable(dev_out_data)));
  // R11
  err_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !reg_wr) |=> (err && !busy && !mem_req));
  // R3
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

bind dma_desc_engine dma_desc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
  .dev_in_ready(dev_in_ready), .dev_in_valid(dev_in_valid), .dev_out_valid(dev_out_valid),
  .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data), .busy(busy), .err(err), .ptr(tbl_ptr)
);

// File: tb/sim_dma_desc_engine.sv
`timescale 1ns/1ps
module sim_dma_desc_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [15:0] dev_in_data;
  logic        dev_in_valid, dev_in_ready;
  logic [15:0] dev_out_data;
  logic        dev_out_valid, dev_out_ready, dev_done;
  logic        dev_irq = 1'b0;
  logic        irq;

  dma_desc_engine u0 (.*);

  int checks = 0, errors = 0;
  logic [31:0] tbl [0:7];
  logic [15:0] wmem [0:511];
  logic [511:0] wvalid = '0;
  logic [15:0] sink [0:15];
  logic        mem_clr = 1'b0, dev_clr = 1'b0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          acc_cnt = 0;
  logic [7:0]  dcnt = '0;
  logic [7:0]  dev_total = '0;
  logic        dev_dir = 1'b1, dev_hold = 1'b0, stall_en = 1'b0;
  logic [31:0] cyc = '0;

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction
  function automatic logic [31:0] mread(input logic [31:0] a);
    if (a >= 32'h40 && a < 32'h60) return tbl[(a - 32'h40) >> 2];
    return {16'h0, wvalid[a[9:1]] ? wmem[a[9:1]] : pat(a)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_clr) wvalid <= '0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      acc_cnt <= acc_cnt + 1;
      mem_rdata <= mread(mem_addr);
      mem_err <= err_en && mem_addr == err_addr;
      if (mem_we && !(err_en && mem_addr == err_addr)) begin
        wmem[mem_addr[9:1]] <= mem_wdata;
        wvalid[mem_addr[9:1]] <= 1'b1;
      end
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  assign dev_in_data   = 16'hC000 + {8'h0, dcnt};
  assign dev_in_valid  = dev_dir && !dev_hold && dcnt < dev_total;
  assign dev_out_ready = !dev_dir && !(stall_en && cyc[0]) && dcnt < dev_total;
  assign dev_done      = dcnt >= dev_total;

  always @(posedge clk) begin
    if (dev_clr) dcnt <= '0;
    else if ((dev_in_valid && dev_in_ready) || (dev_out_valid && dev_out_ready)) begin
      if (!dev_dir) sink[dcnt[3:0]] <= dev_out_data;
      dcnt <= dcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b0; #1; d = reg_rdata;
  endtask
  task automatic pulse_clr();
    @(negedge clk); mem_clr = 1'b1; dev_clr = 1'b1;
    @(negedge clk); mem_clr = 1'b0; dev_clr = 1'b0;
  endtask
  task automatic poll(output logic [7:0] s);
    s = 8'h01;
    for (int i = 0; i < 600; i++) begin
      rd(3'd2, s);
      if (!s[0] || s[2]) break;
    end
  endtask
  task automatic set_ptr(input logic [31:0] p);
    wr(3'd4, p[7:0]); wr(3'd5, p[15:8]); wr(3'd6, p[23:16]); wr(3'd7, p[31:24]);
  endtask
  task automatic prep(input logic dir, input logic [7:0] n);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h06);
    dev_dir = dir; dev_total = n;
    pulse_clr();
  endtask

  function automatic logic [31:0] buf_at(input int j);
    return j < 3 ? 32'h100 + 2 * j : 32'h200 + 2 * (j - 3);
  endfunction

  initial begin
    logic [7:0] s, exp_s;
    int k, a0;
    tbl[0] = 32'h100; tbl[1] = 32'h6; tbl[2] = 32'h200; tbl[3] = 32'h80000004;
    for (int i = 4; i < 8; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd2, s); chk("R1 reset status", s, 8'h00);
    rd(3'd0, s); chk("R1 reset command", s, 8'h00);
    rd(3'd4, s); chk("R1 reset pointer", s, 8'h00);
    chk("R12 reset irq", irq, 1'b0);
    chk("R3 reset no request", mem_req, 1'b0);

    set_ptr(32'h12345677);
    rd(3'd4, s); chk("R2 pointer low bits", s, 8'h74);
    rd(3'd5, s); chk("R1 pointer byte1", s, 8'h56);
    rd(3'd7, s); chk("R1 pointer byte3", s, 8'h12);
    rd(3'd1, s); chk("R1 offset1 reads 0", s, 8'h00);
    rd(3'd3, s); chk("R1 offset3 reads 0", s, 8'h00);
    set_ptr(32'h40);

    dev_irq = 1'b1; #1; chk("R12 device request", irq, 1'b1);
    dev_irq = 1'b0; #1; chk("R12 both low", irq, 1'b0);

    for (int dir = 0; dir < 2; dir++) begin
      for (int n = 1; n <= 7; n++) begin
        prep(dir[0], n[7:0]);
        stall_en = !dir[0] && n[0];
        wr(3'd0, dir[0] ? 8'h09 : 8'h01);
        poll(s);
        exp_s = n < 5 ? 8'h05 : (n == 5 ? 8'h04 : 8'h00);
        if (n < 5) chk($sformatf("R8 long dir=%0d n=%0d", dir, n), s, exp_s);
        else if (n == 5) chk($sformatf("R6 exact dir=%0d n=%0d", dir, n), s, exp_s);
        else chk($sformatf("R7 short dir=%0d n=%0d", dir, n), s, exp_s);
        k = n < 5 ? n : 5;
        repeat (4) @(negedge clk);
        chk($sformatf("R7 words moved dir=%0d n=%0d", dir, n), dcnt, k);
        for (int j = 0; j < k; j++) begin
          if (dir == 1) begin
            a0 = buf_at(j);
            chk($sformatf("R5 mem write dir=1 n=%0d w=%0d", n, j),
                wvalid[a0[9:1]] ? {16'h0, wmem[a0[9:1]]} : 32'hDEAD, 32'hC000 + j);
          end else begin
            chk($sformatf("R5 R13 device word dir=0 n=%0d w=%0d", n, j), sink[j], pat(buf_at(j)));
          end
        end
        if (dir == 1) begin
          chk("R3 first buffer bound", wvalid[9'h83], 1'b0);
          chk("R3 last buffer bound", wvalid[9'h102], 1'b0);
        end
        if (n < 5) begin
          a0 = acc_cnt;
          if (dir == 1 && n == 2) begin
            wr(3'd4, 8'h80);
            rd(3'd4, s); chk("R2 pointer write while active", s, 8'h40);
            wr(3'd0, 8'h09);
          end
          repeat (10) @(negedge clk);
          chk("R8 no access after long finish", acc_cnt, a0);
          chk("R12 irq from status", irq, 1'b1);
          wr(3'd0, 8'h00);
          rd(3'd2, s); chk("R9 stop keeps interrupt", s, 8'h04);
        end
        if (n == 5) begin
          wr(3'd2, 8'h02);
          rd(3'd2, s); chk("R10 writing error bit keeps interrupt", s, 8'h04);
          wr(3'd2, 8'h04);
          rd(3'd2, s); chk("R10 interrupt cleared", s, 8'h00);
        end
      end
    end
    stall_en = 1'b0;

    tbl[0] = 32'h301; tbl[1] = 32'h80000000;
    prep(1'b1, 8'd3);
    wr(3'd0, 8'h09); poll(s);
    chk("R4 zero size means 64K", s, 8'h05);
    chk("R4 address bit0 ignored", wvalid[9'h180] ? {16'h0, wmem[9'h180]} : 32'hDEAD, 32'hC000);
    chk("R4 third word", wvalid[9'h182] ? {16'h0, wmem[9'h182]} : 32'hDEAD, 32'hC002);

    tbl[0] = 32'h300; tbl[1] = 32'h80000005;
    prep(1'b1, 8'd3);
    wr(3'd0, 8'h09); poll(s);
    repeat (4) @(negedge clk);
    chk("R4 odd size rounds down", s, 8'h00);
    chk("R4 odd size two words", dcnt, 8'd2);
    chk("R4 odd size bound", wvalid[9'h182], 1'b0);

    tbl[0] = 32'h100; tbl[1] = 32'h6;
    prep(1'b1, 8'd5);
    err_en = 1'b1; err_addr = 32'h102;
    wr(3'd0, 8'h09); poll(s);
    chk("R11 error status", s, 8'h06);
    a0 = acc_cnt;
    repeat (8) @(negedge clk);
    chk("R11 no access after error", acc_cnt, a0);
    err_en = 1'b0;
    wr(3'd2, 8'h02);
    rd(3'd2, s); chk("R10 error cleared", s, 8'h04);
    wr(3'd2, 8'h04);
    rd(3'd2, s); chk("R10 interrupt cleared after error", s, 8'h00);

    prep(1'b1, 8'd4);
    dev_hold = 1'b1;
    wr(3'd0, 8'h09);
    repeat (10) @(negedge clk);
    rd(3'd2, s); chk("R9 waiting on device", s, 8'h01);
    rd(3'd0, s); chk("R1 command readback", s, 8'h09);
    wr(3'd0, 8'h00);
    rd(3'd2, s); chk("R9 stop clears active", s, 8'h00);
    a0 = acc_cnt;
    dev_hold = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 no access after stop", acc_cnt, a0);
    chk("R9 no device word after stop", dcnt, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule